// File: doc/BRIEF.md
# Ripple-Carry Integer ALU with Signed Compare

This block is a purely combinational integer arithmetic logic unit. It is built from a row of identical one-bit slices joined by a ripple carry chain. It takes two operands of `WIDTH` bits and a 3-bit operation code. It returns a result word, a flag that is set when the result word is all zeros, and a signed overflow flag.

The top bit of the operation code inverts the second operand and sets the carry into the lowest slice. This turns the adder into a subtractor. The two low bits of the code choose what each slice passes to its result bit: the AND term, the OR term, the sum, or a compare input. Only the lowest slice has a live compare input. It takes the signed "less than" decision that the top slice forms during the subtraction, so a signed compare yields 0 or 1 in the least significant result bit.

The block has no clock and no state. A datapath places it between operand registers and a result register. It tests equality by issuing a subtract and reading the zero flag.

Top module: `ripple_alu`

## Requirements
- R1: Operation code 3'b000 drives the result with the bitwise AND of the two operands.
- R2: Operation code 3'b001 drives the result with the bitwise OR of the two operands.
- R3: Operation code 3'b010 drives the result with the sum of the operands, modulo 2^WIDTH.
- R4: Operation code 3'b110 drives the result with the first operand minus the second, modulo 2^WIDTH.
- R5: Operation code 3'b111 drives result bit 0 high exactly when the first operand is less than the second, both read as two's complement. This holds even when the internal subtraction overflows. All other result bits are 0.
- R6: The zero flag is 1 if and only if every bit of the result is 0. After a subtract, it is therefore 1 exactly when the operands are equal.
- R7: The overflow flag is set for codes 3'b010 and 3'b110 only, and only when the true signed result does not fit in WIDTH bits. It is 0 for every other code, and an add of two operands of differing signs never sets it.
- R8: The unused codes 3'b011, 3'b100 and 3'b101 give an all-zero result with the overflow flag clear, and so with the zero flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand (inverted for subtract and compare) |
| op_i | input | 3 | Operation code |
| result_o | output | WIDTH | Result word |
| zero_o | output | 1 | Result is all zeros |
| ovf_o | output | 1 | Signed overflow on add or subtract |

## Verification
The checker assumes that the operands and the operation code are fully known: no X or Z bits. Each of its checks is skipped while any input bit is unknown. The bench sets every input to a defined value before its first sample and only ever drives defined values afterwards. A narrow 4-bit instance receives every operand pair under all eight codes, which covers each overflow and compare corner. The 32-bit instance receives the extreme values together with pseudo-random words.

// File: rtl/ripple_alu_pkg.sv
package ripple_alu_pkg;
  typedef enum logic [2:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;

  // Per-slice output selector (low two bits of the operation code)
  localparam logic [1:0] SEL_AND  = 2'b00;
  localparam logic [1:0] SEL_OR   = 2'b01;
  localparam logic [1:0] SEL_SUM  = 2'b10;
  localparam logic [1:0] SEL_LESS = 2'b11;
endpackage

// File: rtl/ripple_alu_slice.sv
module ripple_alu_slice
  import ripple_alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       cin_i,
  input  logic       less_i,
  input  logic       bneg_i,
  input  logic [1:0] sel_i,
  output logic       res_o,
  output logic       sum_o,
  output logic       cout_o
);
  logic b_eff;

  assign b_eff  = b_i ^ bneg_i;
  assign sum_o  = a_i ^ b_eff ^ cin_i;
  assign cout_o = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);

  always_comb begin
    unique case (sel_i)
      SEL_AND:  res_o = a_i & b_eff;
      SEL_OR:   res_o = a_i | b_eff;
      SEL_SUM:  res_o = sum_o;
      default:  res_o = less_i;
    endcase
  end
endmodule

// File: rtl/ripple_alu_zero.sv
module ripple_alu_zero #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic             zero_o
);
  assign zero_o = ~|vec_i;
endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
  import ripple_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic bneg;
  logic op_known;
  logic op_arith;
  logic ovf_raw;
  logic set_lt;
  logic carry     [WIDTH+1];
  logic slice_res [WIDTH];
  logic slice_sum [WIDTH];
  logic [WIDTH-1:0] res_vec;

  assign bneg     = op_i[2];
  assign carry[0] = bneg;

  always_comb begin
    unique case (op_i)
      OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT: op_known = 1'b1;
      default:                               op_known = 1'b0;
    endcase
    op_arith = (op_i == OP_ADD) || (op_i == OP_SUB);
  end

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_slice
      logic less_in;
      if (gi == 0) begin : g_lsb
        assign less_in = set_lt;
      end else begin : g_hi
        assign less_in = 1'b0;
      end
      ripple_alu_slice u_slice (
        .a_i    (a_i[gi]),
        .b_i    (b_i[gi]),
        .cin_i  (carry[gi]),
        .less_i (less_in),
        .bneg_i (bneg),
        .sel_i  (op_i[1:0]),
        .res_o  (slice_res[gi]),
        .sum_o  (slice_sum[gi]),
        .cout_o (carry[gi+1])
      );
    end
  endgenerate

  // Top slice: overflow from carry disagreement, corrected sign for compare
  assign ovf_raw = carry[MSB] ^ carry[WIDTH];
  assign set_lt  = slice_sum[MSB] ^ ovf_raw;

  always_comb begin
    for (int i = 0; i < WIDTH; i++) res_vec[i] = slice_res[i];
  end

  assign result_o = op_known ? res_vec : '0;
  assign ovf_o    = op_arith & ovf_raw;

  ripple_alu_zero #(.WIDTH(WIDTH)) u_zero (
    .vec_i  (result_o),
    .zero_o (zero_o)
  );
endmodule

// File: rtl/ripple_alu_checker.sv
module ripple_alu_checker #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             ovf_o
);
  logic known;
  assign known = !$isunknown({a_i, b_i, op_i});

  always_comb begin
    if (known) begin
      AST_AND_BITS: assert (op_i != 3'b000 || result_o == (a_i & b_i)); // R1
      AST_OR_BITS: assert (op_i != 3'b001 || result_o == (a_i | b_i)); // R2
      AST_ADD_SUM: assert (op_i != 3'b010 || result_o == a_i + b_i); // R3
      AST_SUB_DIFF: assert (op_i != 3'b110 || result_o == a_i - b_i); // R4
      AST_SLT_UPPER: assert (op_i != 3'b111 || result_o[WIDTH-1:1] == '0); // R5
      AST_SLT_VALUE: assert (op_i != 3'b111 || result_o[0] == ($signed(a_i) < $signed(b_i))); // R5
      AST_SUB_EQUAL: assert (op_i != 3'b110 || zero_o == (a_i == b_i)); // R6
      AST_NO_OVERFLOW: assert (op_i == 3'b010 || op_i == 3'b110 || !ovf_o); // R7
      AST_MIXED_ADD: assert (op_i != 3'b010 || a_i[WIDTH-1] == b_i[WIDTH-1] || !ovf_o); // R7
      AST_UNUSED_CLEAR: assert (!(op_i == 3'b011 || op_i == 3'b100 || op_i == 3'b101)
                                || (zero_o && !ovf_o)); // R8
    end
  end
endmodule

bind ripple_alu ripple_alu_checker #(.WIDTH(WIDTH)) u_checker (
  .a_i      (a_i),
  .b_i      (b_i),
  .op_i     (op_i),
  .result_o (result_o),
  .zero_o   (zero_o),
  .ovf_o    (ovf_o)
);

// File: tb/ripple_alu_bench.sv
module ripple_alu_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [3:0]  na, nb;
  logic [2:0]  nop;
  logic [3:0]  nres;
  logic        nzero, novf;
  logic [31:0] wa, wb;
  logic [2:0]  wop;
  logic [31:0] wres;
  logic        wzero, wovf;

  ripple_alu #(.WIDTH(4)) u_ripple_alu (
    .a_i(na), .b_i(nb), .op_i(nop), .result_o(nres), .zero_o(nzero), .ovf_o(novf)
  );
  ripple_alu #(.WIDTH(32)) u_ripple_alu_w32 (
    .a_i(wa), .b_i(wb), .op_i(wop), .result_o(wres), .zero_o(wzero), .ovf_o(wovf)
  );

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'b000:  return "R1";
      3'b001:  return "R2";
      3'b010:  return "R3/R7";
      3'b110:  return "R4/R6/R7";
      3'b111:  return "R5";
      default: return "R8";
    endcase
  endfunction

  // Arithmetic reference model on 64-bit integers
  task automatic model(input longint a, input longint b, input logic [2:0] op,
                       input int w, output longint r, output bit v);
    longint m  = longint'(1) << w;
    longint h  = m >> 1;
    longint sa = (a >= h) ? a - m : a;
    longint sb = (b >= h) ? b - m : b;
    longint s;
    v = 1'b0;
    case (op)
      3'b000: r = a & b;
      3'b001: r = a | b;
      3'b010: begin s = sa + sb; r = (a + b) % m; v = (s >= h) || (s < -h); end
      3'b110: begin s = sa - sb; r = (a - b + m) % m; v = (s >= h) || (s < -h); end
      3'b111: r = (sa < sb) ? 1 : 0;
      default: r = 0;
    endcase
  endtask

  task automatic compare(input longint a, input longint b, input logic [2:0] op, input int w,
                         input longint gr, input bit gz, input bit gv);
    longint er;
    bit ev;
    model(a, b, op, w, er, ev);
    checks++;
    if (gr != er || gz != (er == 0) || gv != ev) begin
      errors++;
      $display("FAIL %s (R6 zero) a=%0h b=%0h op=%b: got res=%0h z=%0b v=%0b, expected res=%0h z=%0b v=%0b",
               req_of(op), a, b, op, gr, gz, gv, er, (er == 0), ev);
    end
  endtask

  task automatic run_narrow(input logic [3:0] a, input logic [3:0] b, input logic [2:0] op);
    @(negedge clk);
    na = a; nb = b; nop = op;
    #1;
    compare(longint'(a), longint'(b), op, 4, longint'(nres), nzero, novf);
  endtask

  task automatic run_wide(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op);
    @(negedge clk);
    wa = a; wb = b; wop = op;
    #1;
    compare(longint'(a), longint'(b), op, 32, longint'(wres), wzero, wovf);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  logic [31:0] corner [5];
  logic [31:0] lfsr;

  initial begin
    na = '0; nb = '0; nop = 3'b000;
    wa = '0; wb = '0; wop = 3'b000;
    corner[0] = 32'h0000_0000;
    corner[1] = 32'h0000_0001;
    corner[2] = 32'hFFFF_FFFF;
    corner[3] = 32'h7FFF_FFFF;
    corner[4] = 32'h8000_0000;
    @(negedge clk);
    #1;
    // Initial state: AND of zeros gives zero result and zero flag (R1, R6)
    checks++;
    if (nres !== 4'h0 || nzero !== 1'b1 || novf !== 1'b0) begin
      errors++;
      $display("FAIL R6 initial: got res=%0h z=%0b v=%0b, expected res=0 z=1 v=0", nres, nzero, novf);
    end
    // Exhaustive sweep of the 4-bit instance, every code (R1..R8)
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          run_narrow(4'(a), 4'(b), 3'(op));
    // Extreme values on the 32-bit instance (R5 overflowing compare, R7)
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          run_wide(corner[i], corner[j], 3'(op));
    // Pseudo-random words on the 32-bit instance
    lfsr = 32'hACE1_2468;
    for (int k = 0; k < 400; k++) begin
      logic [31:0] ra;
      ra = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      run_wide(ra, (k % 5 == 0) ? ra : lfsr, 3'(k % 8));
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule